// File: doc/BRIEF.md
# E-Clock Synchronous Bus Slave

This block lets an 8-bit microcontroller with a synchronous E-clock bus reach a small internal storage array. The external E clock, active-low chip select, read/write line, 13-bit address and 8-bit write data are all asynchronous to the block. A much faster internal clock, at least ten times the E rate, samples them through a synchroniser chain. The block then finds the edges of E in the sampled stream.

A rising edge of E with chip select low and the read/write line high starts a read. The block emits a one-cycle read strobe and fetches the addressed word from a synchronous-read array. It then drives the word with an output enable meant for an external tri-state buffer, and holds that enable until just after E falls again. A falling edge of E with chip select low and the read/write line low commits a write. The block emits a one-cycle write strobe and stores the data byte. Address and data are taken from the synchronised samples that belong to the qualifying edge, so the bus needs to hold them only briefly after that edge.

Top module: `eclk_bus_slave`

## Requirements
- R1: A sampled rising edge of `e_clk` with `cs_n`=0 and `r_w`=1 gives exactly one `rd_stb` pulse, one cycle long. The pulse is high in the cycle after the third rising clock edge, counting the edge that first samples `e_clk` high as the first.
- R2: A sampled falling edge of `e_clk` with `cs_n`=0 and `r_w`=0 gives exactly one `wr_stb` pulse, one cycle long. The pulse follows the third clock edge after `e_clk` is first sampled low, and `wdata` is stored at the sampled address.
- R3: For a qualified read, `rdata` holds the stored word and `rdata_oe` is 1 from the fourth clock edge after `e_clk` is first sampled high. Read and write strobes never coincide.
- R4: `rdata_oe` returns to 0 at the third clock edge after `e_clk` is first sampled low, which is one cycle after the synchronised falling edge. It is 0 at all other times outside a qualified read.
- R5: Edges of `e_clk` seen while `cs_n`=1 give no strobe, leave `rdata_oe` at 0 and leave the storage unchanged.
- R6: A rising edge with `r_w`=0 starts no read, and a falling edge with `r_w`=1 commits no write.
- R7: Only the low `MEM_AW` address bits select a word, so addresses that differ only in bits 12..`MEM_AW` reach the same word.
- R8: While `rst` is high, `rd_stb`, `wr_stb` and `rdata_oe` are 0.
- R9: Address and write data are taken from the samples taken together with the qualifying E edge. A change one clock after that edge has no effect on the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, at least 10x the E rate |
| rst | input | 1 | Synchronous active-high reset |
| e_clk | input | 1 | External E clock (asynchronous) |
| cs_n | input | 1 | Chip select, active low |
| r_w | input | 1 | 1 = read, 0 = write |
| addr | input | 13 | Bus address |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data toward the bus |
| rdata_oe | output | 1 | Enable for the external data-bus driver |
| rd_stb | output | 1 | One-cycle internal read strobe |
| wr_stb | output | 1 | One-cycle internal write strobe |

## Verification
The bench builds the block with `MEM_AW`=4 and `SYNC_STAGES`=2, which gives a 16-word array. A full write-then-read sweep of every word then stays short. Addresses with upper bits set fold onto words that were already written, so aliasing can be seen directly. The two-stage chain fixes the edge-to-strobe and edge-to-data latencies that the reference model predicts cycle by cycle. E runs at about one tenth of the clock rate.

// File: rtl/eclk_pkg.sv
package eclk_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              e;
    logic              cs_n;
    logic              rw;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);
  localparam bus_smp_t BUS_IDLE = '{e: 1'b0, cs_n: 1'b1, rw: 1'b1,
                                    addr: '0, data: '0};
endpackage

// File: rtl/eclk_sync.sv
module eclk_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eclk_phase.sv
module eclk_phase
  import eclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_smp_t          smp,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic              oe
);
  logic e_prev;
  logic rise, fall, rd_go, wr_go;

  assign rise  = smp.e & ~e_prev;
  assign fall  = ~smp.e & e_prev;
  assign rd_go = rise & ~smp.cs_n & smp.rw;
  assign wr_go = fall & ~smp.cs_n & ~smp.rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_prev   <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      oe       <= 1'b0;
      acc_addr <= '0;
      acc_data <= '0;
    end else begin
      e_prev <= smp.e;
      rd_stb <= rd_go;
      wr_stb <= wr_go;
      if (rd_go || wr_go) acc_addr <= smp.addr;
      if (wr_go) acc_data <= smp.data;
      if (fall) oe <= 1'b0;
      else if (rd_stb) oe <= 1'b1;
    end
  end

  a_r1_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);
  a_r2_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));
  a_r3_oe_after_rd: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(rd_stb));
  a_r4_oe_release: assert property (@(posedge clk) disable iff (rst)
    (!smp.e && e_prev) |=> !oe);
  a_r5_cs_blocks: assert property (@(posedge clk) disable iff (rst)
    smp.cs_n |=> (!rd_stb && !wr_stb));
  a_r6_rd_needs_rw: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> $past(smp.rw));
endmodule

// File: rtl/eclk_store.sv
module eclk_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/eclk_bus_slave.sv
module eclk_bus_slave
  import eclk_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_clk,
  input  logic              cs_n,
  input  logic              r_w,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              rd_stb,
  output logic              wr_stb
);
  bus_smp_t          raw, smp;
  logic [SMP_W-1:0]  smp_bits;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;
  logic [ADDR_W-MEM_AW-1:0] unused_hi;

  assign raw = '{e: e_clk, cs_n: cs_n, rw: r_w, addr: addr, data: wdata};

  eclk_sync #(.W(SMP_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(smp_bits)
  );
  assign smp = bus_smp_t'(smp_bits);

  eclk_phase u_phase (
    .clk(clk), .rst(rst), .smp(smp),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .acc_addr(acc_addr), .acc_data(acc_data), .oe(rdata_oe)
  );

  assign unused_hi = acc_addr[ADDR_W-1:MEM_AW];

  eclk_store #(.AW(MEM_AW), .DW(DATA_W)) u_store (
    .clk(clk),
    .we(wr_stb), .waddr(acc_addr[MEM_AW-1:0]), .wdata(acc_data),
    .re(rd_stb), .raddr(acc_addr[MEM_AW-1:0]), .q(rdata)
  );

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_stb && !wr_stb && !rdata_oe));
  a_r3_oe_one_after_stb: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rdata_oe);
endmodule

// File: tb/eclk_bus_slave_bench.sv
module eclk_bus_slave_bench;
  localparam int AW_MEM = 4;
  localparam int DEPTH  = 1 << AW_MEM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        e_clk = 1'b0, cs_n = 1'b1, r_w = 1'b1;
  logic [12:0] addr  = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe, rd_stb, wr_stb;

  eclk_bus_slave #(.MEM_AW(AW_MEM), .SYNC_STAGES(2)) u_eclk_bus_slave (
    .clk(clk), .rst(rst), .e_clk(e_clk), .cs_n(cs_n), .r_w(r_w),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  int    n_run = 0, n_fail = 0, cyc = 0;
  string tag = "R8";

  // behavioural reference: events scheduled by clock number
  bit prev_e = 1'b0;
  int mem_m [DEPTH];
  bit sch_rd [int];
  bit sch_wr [int];
  bit sch_on [int];
  bit sch_off[int];
  int sch_q  [int];
  bit m_rd = 1'b0, m_wr = 1'b0, m_oe = 1'b0;
  int m_q = 0;

  task automatic check(int act, int exp, string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d: actual %0h expected %0h", req, tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      prev_e = 1'b0; m_rd = 1'b0; m_wr = 1'b0; m_oe = 1'b0;
    end else begin
      if (e_clk && !prev_e && !cs_n && r_w) begin
        sch_rd[cyc+2] = 1'b1;
        sch_q[cyc+3]  = mem_m[int'(addr) % DEPTH];
        sch_on[cyc+3] = 1'b1;
      end
      if (!e_clk && prev_e) begin
        sch_off[cyc+2] = 1'b1;
        if (!cs_n && !r_w) begin
          sch_wr[cyc+2] = 1'b1;
          mem_m[int'(addr) % DEPTH] = int'(wdata);
        end
      end
      prev_e = e_clk;
      m_rd = sch_rd.exists(cyc);
      m_wr = sch_wr.exists(cyc);
      if (sch_off.exists(cyc)) m_oe = 1'b0;
      else if (sch_on.exists(cyc)) m_oe = 1'b1;
      if (sch_q.exists(cyc)) m_q = sch_q[cyc];
    end
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(int'(rd_stb), int'(m_rd), "R1");
      check(int'(wr_stb), int'(m_wr), "R2");
      check(int'(rdata_oe), int'(m_oe), "R4");
      if (m_oe) check(int'(rdata), m_q, "R3");
    end
  end

  // one E period; csn/rw are bus levels, short scrambles addr/data one clock after the edge
  task automatic access(bit csn, bit rw, int a, int d, bit short_hold);
    @(negedge clk);
    cs_n = csn; r_w = rw; addr = 13'(a); wdata = 8'(d);
    repeat (4) @(negedge clk);
    e_clk = 1'b1;
    @(negedge clk);
    if (short_hold && rw) addr = ~13'(a);
    repeat (4) @(negedge clk);
    e_clk = 1'b0;
    @(negedge clk);
    if (short_hold && !rw) begin addr = ~13'(a); wdata = ~8'(d); end
    cs_n = 1'b1; r_w = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(int'(rd_stb), 0, "R8");
    check(int'(wr_stb), 0, "R8");
    check(int'(rdata_oe), 0, "R8");
    rst = 1'b0;
    repeat (3) @(negedge clk);

    tag = "R2 write";
    access(1'b0, 1'b0, 3, 8'hA5, 1'b0);
    access(1'b0, 1'b0, 7, 8'h3C, 1'b0);
    access(1'b0, 1'b0, 13'h1FFF, 8'hFF, 1'b0);
    tag = "R1 R3 read";
    access(1'b0, 1'b1, 3, 0, 1'b0);
    access(1'b0, 1'b1, 7, 0, 1'b0);
    access(1'b0, 1'b1, 15, 0, 1'b0);

    tag = "R7 alias";
    access(1'b0, 1'b0, 13'h0013, 8'h5A, 1'b0);
    access(1'b0, 1'b1, 3, 0, 1'b0);
    access(1'b0, 1'b1, 13'h1003, 0, 1'b0);

    tag = "R5 deselected";
    access(1'b1, 1'b0, 7, 8'h00, 1'b0);
    access(1'b1, 1'b1, 7, 0, 1'b0);
    access(1'b0, 1'b1, 7, 0, 1'b0);

    tag = "R9 short hold";
    access(1'b0, 1'b0, 9, 8'h99, 1'b1);
    access(1'b0, 1'b1, 9, 0, 1'b1);
    access(1'b0, 1'b1, 6, 0, 1'b0);

    tag = "R6 sweep";
    for (int i = 0; i < DEPTH; i++) access(1'b0, 1'b0, i, (i * 37 + 11) & 8'hFF, 1'b0);
    for (int i = DEPTH - 1; i >= 0; i--) access(1'b0, 1'b1, i + 32, 0, 1'b0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule